// File: doc/BRIEF.md
# Tagged Multi-Core Sync Unit

A shared unit that lets several cores coordinate through numbered sync points. Each core has its own request lanes. A post lane announces that the core has finished a phase: it carries a sync ID and nothing else. A wait lane carries three values: a sync ID, a producer selector and a needed event count. The core's stall output stays high until the condition is met.

A selector of 0 asks for a count. The waiter is freed once that many posts on the ID have arrived, from any cores. A selector k in 1..NCORE asks for one producer: the waiter is freed once core port k-1 has posted on that ID. Sync IDs are runtime values. Cores on different IDs never affect each other. The unit keeps a small fully associative table of live IDs. Each row holds a saturating event count and one seen-bit per core.

Protocol:
- A post is one request cycle in which the post request is high and its stall is low. A core holds the request while it is stalled.
- A core keeps its wait request and operands steady until its release pulse, and drops the request right after that pulse.

Top module: `tag_sync_unit`

## Requirements
- R1: After reset the table is empty. With no requests, every stall and release output is 0.
- R2: An accepted post (request high, stall low) adds exactly one event from the posting core to the row of its sync ID.
- R3: A waiter with selector 0 is released once the event count of its ID is at least its needed count. Fewer events keep it stalled.
- R4: A waiter with selector k (1..NCORE) is released only after core port k-1 has posted on its ID. Posts on that ID from other cores leave it stalled.
- R5: Posts that arrive before a wait are remembered. A wait whose condition already holds releases in the cycle after it is accepted.
- R6: Posts from several cores on one ID in the same cycle are all counted.
- R7: Rows for different sync IDs are independent, and no two valid rows hold the same ID.
- R8: A release is a one-cycle pulse on the waiter's port. It appears in the cycle after the satisfying post or wait is accepted. The wait stall is low in the pulse cycle and high in every earlier cycle of the wait.
- R9: The table holds NENTRY rows. A request to a new ID while every row is in use is stalled until a row is freed. At most one row is allocated per cycle.
- R10: A row is freed at the clock edge that ends the release of its last waiter. A request to that ID in the release cycle is stalled for one cycle, and a reuse of the ID then starts from count 0.
- R11: While other waiters on a row are still pending, releasing one of them keeps the row and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tag_req | input | NCORE | Post request, one bit per core |
| tag_id | input | NCORE*IDW | Post sync ID, core c in slice c*IDW |
| tag_stall | output | NCORE | Post not taken this cycle |
| wait_req | input | NCORE | Wait request, held until release |
| wait_src | input | NCORE*SRCW | Producer selector: 0 counts any cores, k means core port k-1 |
| wait_id | input | NCORE*IDW | Wait sync ID |
| wait_cnt | input | NCORE*CNTW | Needed event count (selector 0 only) |
| wait_stall | output | NCORE | Core must stay stalled |
| wait_release | output | NCORE | One-cycle release pulse |

## Verification
Freeing a row and serving a new request on the same ID can fall in one cycle. The bench provokes this in two ways. It posts on an ID in the very cycle a release pulse drains that ID's last waiter. It also holds a post to a new ID against a full table while a wait frees a row. The bench judges both by the stall in the release cycle and its drop one cycle later, and by a later wait on the reused ID that must not see the old count. A second same-cycle case is several cores posting on one ID together, and it is judged by a wait that needs exactly that many events.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

  // add with clamp to a ceiling
  function automatic int unsigned sat_add(input int unsigned base, input int unsigned inc,
                                          input int unsigned ceil);
    return (base + inc > ceil) ? ceil : base + inc;
  endfunction

  // population count of a request vector
  function automatic int unsigned ones(input int unsigned v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 32; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // release condition of one waiter
  function automatic logic wait_met(input logic counting, input int unsigned have,
                                    input int unsigned need, input logic producer_seen);
    return counting ? (have >= need) : producer_seen;
  endfunction

endpackage

// File: rtl/tsu_cam.sv
module tsu_cam #(
  parameter int NENTRY = 8,
  parameter int IDW    = 16,
  localparam int EW    = $clog2(NENTRY)
) (
  input  logic [NENTRY-1:0]     valid,
  input  logic [NENTRY*IDW-1:0] ids,
  input  logic [IDW-1:0]        key,
  output logic                  hit,
  output logic [EW-1:0]         idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int e = NENTRY - 1; e >= 0; e--) begin
      if (valid[e] && ids[e*IDW +: IDW] == key) begin
        hit = 1'b1;
        idx = EW'(e);
      end
    end
  end
endmodule

// File: rtl/tsu_alloc.sv
module tsu_alloc #(
  parameter int NREQ   = 8,
  parameter int NENTRY = 8,
  parameter int IDW    = 16,
  localparam int EW    = $clog2(NENTRY)
) (
  input  logic [NREQ-1:0]     miss,
  input  logic [NREQ*IDW-1:0] rid_flat,
  input  logic [NENTRY-1:0]   valid,
  output logic                fire,
  output logic [IDW-1:0]      new_id,
  output logic [EW-1:0]       slot
);
  logic any_miss;
  logic room;

  always_comb begin
    any_miss = 1'b0;
    new_id   = '0;
    for (int r = NREQ - 1; r >= 0; r--) begin
      if (miss[r]) begin
        any_miss = 1'b1;
        new_id   = rid_flat[r*IDW +: IDW];
      end
    end
    room = 1'b0;
    slot = '0;
    for (int e = NENTRY - 1; e >= 0; e--) begin
      if (!valid[e]) begin
        room = 1'b1;
        slot = EW'(e);
      end
    end
    fire = any_miss & room;
  end
endmodule

// File: rtl/tsu_entry.sv
module tsu_entry
  import tsu_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int IDW   = 16,
  parameter int CNTW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [IDW-1:0]   alloc_id,
  input  logic             drop,
  input  logic [NCORE-1:0] tag_hits,
  output logic             valid,
  output logic [IDW-1:0]   id,
  output logic [CNTW-1:0]  cnt,
  output logic [NCORE-1:0] seen
);
  localparam int unsigned CMAX = (1 << CNTW) - 1;

  int unsigned arrivals;
  assign arrivals = ones(32'(tag_hits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      id    <= '0;
      cnt   <= '0;
      seen  <= '0;
    end else if (drop) begin
      valid <= 1'b0;
      id    <= '0;
      cnt   <= '0;
      seen  <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      id    <= alloc_id;
      cnt   <= CNTW'(sat_add(0, arrivals, CMAX));
      seen  <= tag_hits;
    end else if (valid) begin
      cnt   <= CNTW'(sat_add(32'(cnt), arrivals, CMAX));
      seen  <= seen | tag_hits;
    end
  end
endmodule

// File: rtl/tsu_waiter.sv
module tsu_waiter #(
  parameter int SRCW = 3,
  parameter int EW   = 3,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [SRCW-1:0] src_in,
  input  logic [EW-1:0]   slot_in,
  input  logic [CNTW-1:0] need_in,
  input  logic            done,
  output logic            active,
  output logic [SRCW-1:0] src,
  output logic [EW-1:0]   slot,
  output logic [CNTW-1:0] need
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      src    <= '0;
      slot   <= '0;
      need   <= '0;
    end else if (done) begin
      active <= 1'b0;
    end else if (take) begin
      active <= 1'b1;
      src    <= src_in;
      slot   <= slot_in;
      need   <= need_in;
    end
  end
endmodule

// File: rtl/tag_sync_unit.sv
module tag_sync_unit
  import tsu_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NENTRY = 8,
  parameter int IDW    = 16,
  parameter int CNTW   = 8,
  localparam int SRCW  = $clog2(NCORE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      tag_req,
  input  logic [NCORE*IDW-1:0]  tag_id,
  output logic [NCORE-1:0]      tag_stall,
  input  logic [NCORE-1:0]      wait_req,
  input  logic [NCORE*SRCW-1:0] wait_src,
  input  logic [NCORE*IDW-1:0]  wait_id,
  input  logic [NCORE*CNTW-1:0] wait_cnt,
  output logic [NCORE-1:0]      wait_stall,
  output logic [NCORE-1:0]      wait_release
);
  localparam int NREQ = 2 * NCORE;
  localparam int EW   = $clog2(NENTRY);

  // table state
  logic [NENTRY-1:0]     ent_valid;
  logic [NENTRY*IDW-1:0] ent_id_flat;
  logic [CNTW-1:0]       ent_cnt  [NENTRY];
  logic [NCORE-1:0]      ent_seen [NENTRY];
  logic [NCORE-1:0]      ent_tag  [NENTRY];
  logic [NENTRY-1:0]     ent_free;

  // requester view: posts first, then waits
  logic [NREQ-1:0]     rq, hit, acc, miss;
  logic [NREQ*IDW-1:0] rid_flat;
  logic [EW-1:0]       hidx [NREQ];
  logic [EW-1:0]       tgt  [NREQ];

  // allocation events
  logic            alloc_fire;
  logic [IDW-1:0]  alloc_id;
  logic [EW-1:0]   alloc_idx;

  // waiter state and events
  logic [NCORE-1:0] wv, sat, rel;
  logic [SRCW-1:0]  wsrc  [NCORE];
  logic [EW-1:0]    wslot [NCORE];
  logic [CNTW-1:0]  wneed [NCORE];

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    if (r < NCORE) begin : g_post
      assign rid_flat[r*IDW +: IDW] = tag_id[r*IDW +: IDW];
      assign rq[r] = tag_req[r];
    end else begin : g_wait
      assign rid_flat[r*IDW +: IDW] = wait_id[(r-NCORE)*IDW +: IDW];
      assign rq[r] = wait_req[r-NCORE] & ~wv[r-NCORE];
    end

    tsu_cam #(.NENTRY(NENTRY), .IDW(IDW)) u_cam (
      .valid (ent_valid),
      .ids   (ent_id_flat),
      .key   (rid_flat[r*IDW +: IDW]),
      .hit   (hit[r]),
      .idx   (hidx[r])
    );

    assign miss[r] = rq[r] & ~hit[r];
    assign acc[r]  = rq[r] & (hit[r] ? ~ent_free[hidx[r]]
                                     : (alloc_fire && alloc_id == rid_flat[r*IDW +: IDW]));
    assign tgt[r]  = hit[r] ? hidx[r] : alloc_idx;
  end

  tsu_alloc #(.NREQ(NREQ), .NENTRY(NENTRY), .IDW(IDW)) u_alloc (
    .miss     (miss),
    .rid_flat (rid_flat),
    .valid    (ent_valid),
    .fire     (alloc_fire),
    .new_id   (alloc_id),
    .slot     (alloc_idx)
  );

  // accepted posts routed to their rows
  always_comb begin
    for (int e = 0; e < NENTRY; e++) begin
      for (int i = 0; i < NCORE; i++) begin
        ent_tag[e][i] = acc[i] && (tgt[i] == EW'(e));
      end
    end
  end

  // a row drains when a pulse leaves it with no waiter behind
  always_comb begin
    for (int e = 0; e < NENTRY; e++) begin
      logic rel_on, busy;
      rel_on = 1'b0;
      busy   = 1'b0;
      for (int i = 0; i < NCORE; i++) begin
        if (wv[i] && wslot[i] == EW'(e)) begin
          if (rel[i]) rel_on = 1'b1;
          else        busy   = 1'b1;
        end
      end
      ent_free[e] = rel_on & ~busy;
    end
  end

  for (genvar e = 0; e < NENTRY; e++) begin : g_ent
    tsu_entry #(.NCORE(NCORE), .IDW(IDW), .CNTW(CNTW)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc_fire && alloc_idx == EW'(e)),
      .alloc_id (alloc_id),
      .drop     (ent_free[e]),
      .tag_hits (ent_tag[e]),
      .valid    (ent_valid[e]),
      .id       (ent_id_flat[e*IDW +: IDW]),
      .cnt      (ent_cnt[e]),
      .seen     (ent_seen[e])
    );
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_wt
    tsu_waiter #(.SRCW(SRCW), .EW(EW), .CNTW(CNTW)) u_wt (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (acc[NCORE+i]),
      .src_in  (wait_src[i*SRCW +: SRCW]),
      .slot_in (tgt[NCORE+i]),
      .need_in (wait_cnt[i*CNTW +: CNTW]),
      .done    (rel[i]),
      .active  (wv[i]),
      .src     (wsrc[i]),
      .slot    (wslot[i]),
      .need    (wneed[i])
    );

    always_comb begin
      logic pick;
      pick = 1'b0;
      for (int k = 0; k < NCORE; k++) begin
        if (wsrc[i] == SRCW'(k + 1)) pick = ent_seen[wslot[i]][k];
      end
      sat[i] = wait_met(wsrc[i] == '0, 32'(ent_cnt[wslot[i]]), 32'(wneed[i]), pick);
    end
  end

  assign rel          = wv & sat;
  assign wait_release = rel;
  assign wait_stall   = wait_req & ~rel;
  assign tag_stall    = tag_req & ~acc[NCORE-1:0];

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int NCORE  = 4,
  parameter int NENTRY = 8,
  parameter int IDW    = 16,
  localparam int EW    = $clog2(NENTRY)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCORE-1:0]      wait_release,
  input logic [NENTRY-1:0]     ent_valid,
  input logic [NENTRY*IDW-1:0] ent_id_flat,
  input logic [NENTRY-1:0]     ent_free,
  input logic                  alloc_fire,
  input logic [EW-1:0]         alloc_idx
);
  for (genvar i = 0; i < NCORE; i++) begin : g_pulse
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_release[i] |=> !wait_release[i]); // R8
  end

  for (genvar e = 0; e < NENTRY; e++) begin : g_free
    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ent_free[e] |=> !ent_valid[e]); // R10
  end

  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !ent_valid[alloc_idx]); // R9

  AST_ALLOC_TAKES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> ent_valid[$past(alloc_idx)]); // R9

  for (genvar a = 0; a < NENTRY; a++) begin : g_ua
    for (genvar b = a + 1; b < NENTRY; b++) begin : g_ub
      AST_UNIQUE_IDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[a] && ent_valid[b]) |->
          ent_id_flat[a*IDW +: IDW] != ent_id_flat[b*IDW +: IDW]); // R7
    end
  end
endmodule

bind tag_sync_unit tsu_checker #(.NCORE(NCORE), .NENTRY(NENTRY), .IDW(IDW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wait_release (wait_release),
  .ent_valid    (ent_valid),
  .ent_id_flat  (ent_id_flat),
  .ent_free     (ent_free),
  .alloc_fire   (alloc_fire),
  .alloc_idx    (alloc_idx)
);

// File: tb/sim_tag_sync_unit.sv
module sim_tag_sync_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, IDW = 16, SRCW = 3, CNTW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]      tag_req = '0, tag_stall, wait_req = '0, wait_stall, wait_release;
  logic [N*IDW-1:0]  tag_id = '0, wait_id = '0;
  logic [N*SRCW-1:0] wait_src = '0;
  logic [N*CNTW-1:0] wait_cnt = '0;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_sync_unit u0 (
    .clk(clk), .rst_n(rst_n), .tag_req(tag_req), .tag_id(tag_id), .tag_stall(tag_stall),
    .wait_req(wait_req), .wait_src(wait_src), .wait_id(wait_id), .wait_cnt(wait_cnt),
    .wait_stall(wait_stall), .wait_release(wait_release)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic put_tag(input int c, input int id);
    tag_req[c] = 1'b1; tag_id[c*IDW +: IDW] = IDW'(id);
  endtask
  task automatic clr_tag(input int c); tag_req[c] = 1'b0; endtask
  task automatic put_wait(input int c, input int src, input int id, input int n);
    wait_req[c] = 1'b1; wait_src[c*SRCW +: SRCW] = SRCW'(src);
    wait_id[c*IDW +: IDW] = IDW'(id); wait_cnt[c*CNTW +: CNTW] = CNTW'(n);
  endtask
  task automatic clr_wait(input int c); wait_req[c] = 1'b0; endtask

  task automatic t_reset();
    check(tag_stall == 0 && wait_stall == 0, "R1 stalls in reset", int'(tag_stall | wait_stall), 0);
    check(wait_release == 0, "R1 release in reset", int'(wait_release), 0);
    rst_n = 1'b1;
    step();
    check(wait_release == 0 && wait_stall == 0, "R1 idle after reset", int'(wait_release), 0);
  endtask

  task automatic t_global();
    put_wait(0, 0, 5, 2); #1;
    check(wait_stall[0] == 1, "R8 stall in issue cycle", wait_stall[0], 1);
    step();
    check(wait_release[0] == 0, "R3 no posts yet", wait_release[0], 0);
    put_tag(1, 5); #1;
    check(tag_stall[1] == 0, "R2 post taken", tag_stall[1], 0);
    step(); clr_tag(1); #1;
    check(wait_release[0] == 0, "R2 one event of two", wait_release[0], 0);
    put_tag(2, 5);
    step(); clr_tag(2); #1;
    check(wait_release[0] == 1, "R3 count reached", wait_release[0], 1);
    check(wait_stall[0] == 0, "R8 stall low on pulse", wait_stall[0], 0);
    put_tag(3, 5); #1;
    check(tag_stall[3] == 1, "R10 post stalls while row drains", tag_stall[3], 1);
    clr_wait(0);
    step();
    check(wait_release[0] == 0, "R8 pulse one cycle", wait_release[0], 1'b0);
    check(tag_stall[3] == 0, "R10 post taken on fresh row", tag_stall[3], 0);
    step(); clr_tag(3);
  endtask

  task automatic t_specific();
    step(); put_wait(0, 3, 7, 1);
    step(); put_tag(1, 7);
    step(); clr_tag(1); #1;
    check(wait_release[0] == 0, "R4 other producer ignored", wait_release[0], 0);
    put_tag(2, 7);
    step(); clr_tag(2); #1;
    check(wait_release[0] == 1, "R4 named producer releases", wait_release[0], 1);
    clr_wait(0);
    step();
  endtask

  task automatic t_early();
    step(); put_tag(1, 9); put_tag(2, 9); put_tag(3, 9); #1;
    check(tag_stall == 0, "R6 three posts taken together", int'(tag_stall), 0);
    step(); clr_tag(1); clr_tag(2); clr_tag(3);
    put_wait(0, 0, 9, 3); #1;
    check(wait_release[0] == 0, "R5 not before accept", wait_release[0], 0);
    step();
    check(wait_release[0] == 1, "R5 R6 late wait sees all three", wait_release[0], 1);
    clr_wait(0);
    step();
  endtask

  task automatic t_indep();
    step(); put_wait(0, 0, 100, 2); put_wait(1, 0, 200, 1);
    step(); step(); put_tag(2, 100);
    step(); clr_tag(2); #1;
    check(wait_release[1:0] == 2'b00, "R7 other ID untouched", int'(wait_release[1:0]), 0);
    put_tag(3, 200);
    step(); clr_tag(3); #1;
    check(wait_release[1:0] == 2'b10, "R7 only ID 200 waiter", int'(wait_release[1:0]), 2);
    clr_wait(1); put_tag(3, 100);
    step(); clr_tag(3); #1;
    check(wait_release[0] == 1, "R7 ID 100 reaches two", wait_release[0], 1);
    clr_wait(0);
    step();
  endtask

  task automatic t_multi();
    step(); put_wait(0, 0, 300, 1); put_wait(1, 0, 300, 2);
    step(); put_tag(2, 300);
    step(); clr_tag(2); #1;
    check(wait_release[1:0] == 2'b01, "R11 first waiter only", int'(wait_release[1:0]), 1);
    clr_wait(0);
    step();
    check(wait_release[1] == 0, "R11 second still waits", wait_release[1], 0);
    put_tag(2, 300);
    step(); clr_tag(2); #1;
    check(wait_release[1] == 1, "R11 count kept", wait_release[1], 1);
    clr_wait(1);
    step();
  endtask

  task automatic t_reuse();
    put_wait(0, 0, 300, 1);
    step();
    check(wait_release[0] == 0, "R10 reuse starts at zero", wait_release[0], 0);
    step();
    check(wait_release[0] == 0, "R10 still zero", wait_release[0], 0);
    put_tag(1, 300);
    step(); clr_tag(1); #1;
    check(wait_release[0] == 1, "R10 fresh post releases", wait_release[0], 1);
    clr_wait(0);
    step(); put_wait(0, 0, 5, 1);
    step();
    check(wait_release[0] == 1, "R5 remembered post on ID 5", wait_release[0], 1);
    clr_wait(0);
    step();
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) begin
      step(); put_tag(0, 1000 + k); #1;
      check(tag_stall[0] == 0, "R9 row free", tag_stall[0], 0);
    end
    step(); clr_tag(0); put_tag(1, 2000); #1;
    check(tag_stall[1] == 1, "R9 full table stalls", tag_stall[1], 1);
    step();
    check(tag_stall[1] == 1, "R9 stall held", tag_stall[1], 1);
    put_wait(0, 0, 1000, 1);
    step();
    check(wait_release[0] == 1, "R9 wait on full table hits", wait_release[0], 1);
    check(tag_stall[1] == 1, "R10 draining row not yet free", tag_stall[1], 1);
    clr_wait(0);
    step();
    check(tag_stall[1] == 0, "R9 freed row taken", tag_stall[1], 0);
    step(); clr_tag(1);
    for (int k = 1; k <= 8; k++) begin
      put_wait(0, 0, (k == 8) ? 2000 : 1000 + k, 1);
      step();
      check(wait_release[0] == 1, "R9 drain row", wait_release[0], 1);
      clr_wait(0);
      step();
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_global();
    t_specific();
    t_early();
    t_indep();
    t_multi();
    t_reuse();
    t_full();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule